// File: doc/BRIEF.md
# Audio DSP Boot Download Sequencer

This block drives the boot handshake of a slave audio DSP from the host side. A single start pulse begins the sequence. The block holds the slave in hard reset with the boot-mode strap levels applied, lets the slave settle, and writes the 24-bit download-boot command. It then waits for the slave's ready line and reads one 8-bit status reply. On a go-ahead reply it streams the code image from a valid/ready input port into the write channel. It reads a second status reply and acknowledges success, or it latches a failure class together with the failing byte.

The transport is abstract. It is a 24-bit write channel with a valid/ready handshake, an 8-bit read channel with a request/valid handshake, and one slave ready line whose polarity depends on the transport family. In serial mode the slave is ready when the line is low. In parallel mode it is ready when the line is high. After a successful boot the host pulses a kickstart input, and the block writes a configurable 24-bit kickstart word that releases the slave's decoder from its wait state.

States: `S_IDLE`, `S_RESET` (reset pulse), `S_SETTLE` (post-reset delay), `S_CMD_BOOT` (download-boot write), `S_WAIT1` and `S_READ1` (first reply), `S_STREAM` (image), `S_WAIT2` and `S_READ2` (second reply), `S_ACK` (success acknowledge write), `S_DONE`, `S_KICK` (kickstart write), `S_FAIL`.

Transitions:
- start: `S_IDLE`, `S_DONE` or `S_FAIL` → `S_RESET`.
- pulse end: `S_RESET` → `S_SETTLE`.
- settle end: `S_SETTLE` → `S_CMD_BOOT`.
- write accepted: `S_CMD_BOOT` → `S_WAIT1`, `S_ACK` → `S_DONE`, `S_KICK` → `S_DONE`.
- slave ready: `S_WAIT1` → `S_READ1`, `S_WAIT2` → `S_READ2`.
- timeout: `S_WAIT1` or `S_WAIT2` → `S_FAIL`.
- go-ahead reply: `S_READ1` → `S_STREAM`.
- bad reply: `S_READ1` or `S_READ2` → `S_FAIL`.
- last word: `S_STREAM` → `S_WAIT2`.
- success reply: `S_READ2` → `S_ACK`.
- kickstart: `S_DONE` → `S_KICK`.

Top module: `dsp_boot_seq`

## Requirements
- R1: After start, `slv_rst_n_o` is low for exactly RST_CYCLES clock cycles. While it is low, and during the settle delay, `strap_o` = {STRAP_WR, STRAP_RD, `mode_par_i`} (bit 2 = write line, bit 1 = read line, bit 0 = protocol select). At all other times `strap_o` is 3'b000.
- R2: After reset is released, exactly SETTLE_CYCLES cycles pass before the first write. That first write carries 24'h000004.
- R3: A write holds `wr_valid_o` and `wr_data_o` until `wr_ready_i` is high. The only command words written are 24'h000004, 24'h000005 and `kick_word_i`; 24'h000002 and 24'h000003 are never issued as commands.
- R4: The slave is ready when `slv_rdy_i` is low (`mode_par_i`=0) or high (`mode_par_i`=1). `rd_req_o` rises only after the slave has been seen ready, and it stays high until `rd_valid_i`.
- R5: If the slave is not ready within `timeout_i`+1 cycles of a wait, status becomes error with code 6 and byte 8'h00.
- R6: The first reply 8'h01 starts the image stream. In the stream, words pass in order to the write channel, with `img_ready_o` equal to `wr_ready_i`. The handshake of a word flagged `img_last_i` ends the stream.
- R7: A first reply other than 8'h01 gives error status with no image word accepted. 8'hFD and 8'hFE give code 1, 8'hFB gives code 2, and any other byte (e.g. 8'hFA, 8'hFC, 8'h02) gives code 3. The byte is latched on `err_byte_o`.
- R8: The second reply 8'h02 leads to a write of 24'h000005 and then done status with code 0. 8'hFF gives code 4, 8'hF0 gives code 5, and any other byte gives code 3, with the byte latched.
- R9: In done status a `kick_i` pulse writes `kick_word_i` once, and status then returns to done.
- R10: `status_o` is 0 idle, 1 busy, 2 done, 3 error. Start is taken in idle, done or error, and it clears the error code and byte. Start is ignored while busy.
- R11: After reset the block is idle: `slv_rst_n_o` high, no write valid, no read request, error code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse |
| mode_par_i | input | 1 | 1 = parallel transport, 0 = serial |
| timeout_i | input | TO_W | Ready-wait limit in cycles |
| slv_rst_n_o | output | 1 | Hard reset to slave, active low |
| strap_o | output | 3 | Boot-mode levels {write, read, protocol select} |
| slv_rdy_i | input | 1 | Slave ready line (polarity per mode) |
| wr_valid_o | output | 1 | Write channel valid |
| wr_data_o | output | 24 | Write channel word |
| wr_ready_i | input | 1 | Write channel ready |
| rd_req_o | output | 1 | Read channel request |
| rd_valid_i | input | 1 | Read byte valid |
| rd_data_i | input | 8 | Read byte |
| img_valid_i | input | 1 | Image word valid |
| img_data_i | input | 24 | Image word |
| img_last_i | input | 1 | Final image word marker |
| img_ready_o | output | 1 | Image word accepted |
| kick_i | input | 1 | Kickstart request pulse |
| kick_word_i | input | 24 | Kickstart command word |
| status_o | output | 2 | Idle/busy/done/error |
| err_code_o | output | 3 | Failure class |
| err_byte_o | output | 8 | Failing reply byte |

## Verification
A wrong state in this machine shows up at the write channel within one handshake. An extra, missing or out-of-order word would be flagged the moment it is accepted, because every accepted word is compared against an expected list built from the reply bytes fed to the slave model. A stuck or skipped wait shows as a read request that appears while the slave is not ready, or as a timeout code in place of done. Miscounted delays show directly as the width of the reset pulse or the length of the settle gap, measured in cycles at the pins.

// File: rtl/dbs_pkg.sv
`timescale 1ns/1ps
package dbs_pkg;

    localparam int CMD_W = 24;
    localparam int RPL_W = 8;

    localparam logic [CMD_W-1:0] CMD_DL_BOOT  = 24'h000004;
    localparam logic [CMD_W-1:0] CMD_BOOT_ACK = 24'h000005;

    typedef enum logic [3:0] {
        S_IDLE, S_RESET, S_SETTLE, S_CMD_BOOT, S_WAIT1, S_READ1, S_STREAM,
        S_WAIT2, S_READ2, S_ACK, S_DONE, S_KICK, S_FAIL
    } state_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_DONE = 2'd2, ST_ERROR = 2'd3
    } stat_e;

    typedef enum logic [2:0] {
        E_NONE = 3'd0, E_INIT = 3'd1, E_INVALID = 3'd2, E_BOOT = 3'd3,
        E_CKSUM = 3'd4, E_APP = 3'd5, E_TIMEOUT = 3'd6
    } err_e;

    typedef enum logic [2:0] {
        RP_START, RP_SUCCESS, RP_INIT, RP_INVALID, RP_BOOT, RP_APP, RP_CKSUM, RP_OTHER
    } reply_e;

endpackage

// File: rtl/dbs_countdown.sv
`timescale 1ns/1ps
module dbs_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dbs_reply_decode.sv
`timescale 1ns/1ps
module dbs_reply_decode
    import dbs_pkg::*;
(
    input  logic [RPL_W-1:0] byte_i,
    output reply_e           kind_o
);
    always_comb begin
        unique case (byte_i)
            8'h01:        kind_o = RP_START;
            8'h02:        kind_o = RP_SUCCESS;
            8'hF0:        kind_o = RP_APP;
            8'hFA, 8'hFC: kind_o = RP_BOOT;
            8'hFB:        kind_o = RP_INVALID;
            8'hFD, 8'hFE: kind_o = RP_INIT;
            8'hFF:        kind_o = RP_CKSUM;
            default:      kind_o = RP_OTHER;
        endcase
    end
endmodule

// File: rtl/dsp_boot_seq.sv
`timescale 1ns/1ps
module dsp_boot_seq
    import dbs_pkg::*;
#(
    parameter int         RST_CYCLES    = 16,
    parameter int         SETTLE_CYCLES = 8,
    parameter int         TO_W          = 16,
    parameter logic       STRAP_WR      = 1'b1,
    parameter logic       STRAP_RD      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_par_i,
    input  logic [TO_W-1:0]  timeout_i,
    output logic             slv_rst_n_o,
    output logic [2:0]       strap_o,
    input  logic             slv_rdy_i,
    output logic             wr_valid_o,
    output logic [CMD_W-1:0] wr_data_o,
    input  logic             wr_ready_i,
    output logic             rd_req_o,
    input  logic             rd_valid_i,
    input  logic [RPL_W-1:0] rd_data_i,
    input  logic             img_valid_i,
    input  logic [CMD_W-1:0] img_data_i,
    input  logic             img_last_i,
    output logic             img_ready_o,
    input  logic             kick_i,
    input  logic [CMD_W-1:0] kick_word_i,
    output logic [1:0]       status_o,
    output logic [2:0]       err_code_o,
    output logic [RPL_W-1:0] err_byte_o
);
    localparam int DLY_MAX = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam int CNT_W   = (DLY_W > TO_W) ? DLY_W : TO_W;
    localparam logic [CNT_W-1:0] RST_LD    = CNT_W'(RST_CYCLES - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYCLES - 1);

    state_e           state_q, state_n;
    err_e             err_q, fail_code;
    logic [RPL_W-1:0] ebyte_q, fail_byte;
    logic             fail, clr_err;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             cnt_zero;
    logic             slave_ready;
    reply_e           kind;

    assign slave_ready = mode_par_i ? slv_rdy_i : ~slv_rdy_i;

    dbs_countdown #(.W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ld),
        .value_i (ld_val),
        .zero_o  (cnt_zero)
    );

    dbs_reply_decode dec_i (
        .byte_i (rd_data_i),
        .kind_o (kind)
    );

    // next state, counter loads and error capture
    always_comb begin
        state_n   = state_q;
        ld        = 1'b0;
        ld_val    = '0;
        fail      = 1'b0;
        fail_code = E_NONE;
        fail_byte = '0;
        clr_err   = 1'b0;
        unique case (state_q)
            S_IDLE, S_FAIL, S_DONE: begin
                if (start_i) begin
                    state_n = S_RESET;
                    ld      = 1'b1;
                    ld_val  = RST_LD;
                    clr_err = 1'b1;
                end else if (state_q == S_DONE && kick_i) begin
                    state_n = S_KICK;
                end
            end
            S_RESET: begin
                if (cnt_zero) begin
                    state_n = S_SETTLE;
                    ld      = 1'b1;
                    ld_val  = SETTLE_LD;
                end
            end
            S_SETTLE: begin
                if (cnt_zero) state_n = S_CMD_BOOT;
            end
            S_CMD_BOOT: begin
                if (wr_ready_i) begin
                    state_n = S_WAIT1;
                    ld      = 1'b1;
                    ld_val  = CNT_W'(timeout_i);
                end
            end
            S_WAIT1, S_WAIT2: begin
                if (slave_ready) begin
                    state_n = (state_q == S_WAIT1) ? S_READ1 : S_READ2;
                end else if (cnt_zero) begin
                    state_n   = S_FAIL;
                    fail      = 1'b1;
                    fail_code = E_TIMEOUT;
                end
            end
            S_READ1: begin
                if (rd_valid_i) begin
                    if (kind == RP_START) begin
                        state_n = S_STREAM;
                    end else begin
                        state_n   = S_FAIL;
                        fail      = 1'b1;
                        fail_byte = rd_data_i;
                        if (kind == RP_INIT)         fail_code = E_INIT;
                        else if (kind == RP_INVALID) fail_code = E_INVALID;
                        else                         fail_code = E_BOOT;
                    end
                end
            end
            S_STREAM: begin
                if (img_valid_i && wr_ready_i && img_last_i) begin
                    state_n = S_WAIT2;
                    ld      = 1'b1;
                    ld_val  = CNT_W'(timeout_i);
                end
            end
            S_READ2: begin
                if (rd_valid_i) begin
                    if (kind == RP_SUCCESS) begin
                        state_n = S_ACK;
                    end else begin
                        state_n   = S_FAIL;
                        fail      = 1'b1;
                        fail_byte = rd_data_i;
                        if (kind == RP_CKSUM)    fail_code = E_CKSUM;
                        else if (kind == RP_APP) fail_code = E_APP;
                        else                     fail_code = E_BOOT;
                    end
                end
            end
            S_ACK, S_KICK: begin
                if (wr_ready_i) state_n = S_DONE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // state register and latched error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            err_q   <= E_NONE;
            ebyte_q <= '0;
        end else begin
            state_q <= state_n;
            if (clr_err) begin
                err_q   <= E_NONE;
                ebyte_q <= '0;
            end else if (fail) begin
                err_q   <= fail_code;
                ebyte_q <= fail_byte;
            end
        end
    end

    // outputs from state
    always_comb begin
        slv_rst_n_o = 1'b1;
        strap_o     = 3'b000;
        wr_valid_o  = 1'b0;
        wr_data_o   = '0;
        rd_req_o    = 1'b0;
        img_ready_o = 1'b0;
        status_o    = ST_BUSY;
        unique case (state_q)
            S_IDLE:  status_o = ST_IDLE;
            S_DONE:  status_o = ST_DONE;
            S_FAIL:  status_o = ST_ERROR;
            S_RESET: begin
                slv_rst_n_o = 1'b0;
                strap_o     = {STRAP_WR, STRAP_RD, mode_par_i};
            end
            S_SETTLE: strap_o = {STRAP_WR, STRAP_RD, mode_par_i};
            S_CMD_BOOT: begin
                wr_valid_o = 1'b1;
                wr_data_o  = CMD_DL_BOOT;
            end
            S_READ1, S_READ2: rd_req_o = 1'b1;
            S_STREAM: begin
                wr_valid_o  = img_valid_i;
                wr_data_o   = img_data_i;
                img_ready_o = wr_ready_i;
            end
            S_ACK: begin
                wr_valid_o = 1'b1;
                wr_data_o  = CMD_BOOT_ACK;
            end
            S_KICK: begin
                wr_valid_o = 1'b1;
                wr_data_o  = kick_word_i;
            end
            default: status_o = ST_BUSY;
        endcase
    end

    assign err_code_o = err_q;
    assign err_byte_o = ebyte_q;
endmodule

// File: rtl/dbs_boot_seq_chk.sv
`timescale 1ns/1ps
module dbs_boot_seq_chk #(
    parameter logic STRAP_WR = 1'b1,
    parameter logic STRAP_RD = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_par_i,
    input logic        slv_rdy_i,
    input logic        slv_rst_n_o,
    input logic [2:0]  strap_o,
    input logic        wr_valid_o,
    input logic        wr_ready_i,
    input logic [23:0] wr_data_o,
    input logic        rd_req_o,
    input logic        rd_valid_i,
    input logic        img_ready_o,
    input logic [1:0]  status_o,
    input logic [2:0]  err_code_o
);
    AST_STRAP_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_rst_n_o |-> strap_o == {STRAP_WR, STRAP_RD, mode_par_i}); // R1
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_data_o)); // R3
    AST_READ_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req_o) |-> $past(mode_par_i ? slv_rdy_i : !slv_rdy_i)); // R4
    AST_REQ_UNTIL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_valid_i |=> rd_req_o); // R4
    AST_IMG_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready_o |-> status_o == 2'd1); // R6
    AST_DONE_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        status_o == 2'd2 |-> err_code_o == 3'd0); // R8
    AST_ERROR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        status_o == 2'd3 |-> err_code_o != 3'd0); // R10
endmodule

bind dsp_boot_seq dbs_boot_seq_chk #(.STRAP_WR(STRAP_WR), .STRAP_RD(STRAP_RD)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_par_i  (mode_par_i),
    .slv_rdy_i   (slv_rdy_i),
    .slv_rst_n_o (slv_rst_n_o),
    .strap_o     (strap_o),
    .wr_valid_o  (wr_valid_o),
    .wr_ready_i  (wr_ready_i),
    .wr_data_o   (wr_data_o),
    .rd_req_o    (rd_req_o),
    .rd_valid_i  (rd_valid_i),
    .img_ready_o (img_ready_o),
    .status_o    (status_o),
    .err_code_o  (err_code_o)
);

// File: tb/dsp_boot_seq_tb_top.sv
`timescale 1ns/1ps
module dsp_boot_seq_tb_top;
    localparam int   RST = 6;
    localparam int   SET = 3;
    localparam int   TOW = 16;
    localparam logic SWR = 1'b1;
    localparam logic SRD = 1'b0;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n, start_i, mode_par_i, slv_rst_n_o, slv_rdy_i;
    logic [TOW-1:0] timeout_i;
    logic [2:0]     strap_o;
    logic           wr_valid_o, wr_ready_i, rd_req_o, rd_valid_i;
    logic [23:0]    wr_data_o, img_data_i, kick_word_i;
    logic [7:0]     rd_data_i, err_byte_o;
    logic           img_valid_i, img_last_i, img_ready_o, kick_i;
    logic [1:0]     status_o;
    logic [2:0]     err_code_o;

    logic rdy_b;
    assign slv_rdy_i = mode_par_i ? rdy_b : ~rdy_b;

    dsp_boot_seq #(.RST_CYCLES(RST), .SETTLE_CYCLES(SET), .TO_W(TOW),
                   .STRAP_WR(SWR), .STRAP_RD(SRD)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_par_i(mode_par_i),
        .timeout_i(timeout_i), .slv_rst_n_o(slv_rst_n_o), .strap_o(strap_o),
        .slv_rdy_i(slv_rdy_i), .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
        .wr_ready_i(wr_ready_i), .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i),
        .rd_data_i(rd_data_i), .img_valid_i(img_valid_i), .img_data_i(img_data_i),
        .img_last_i(img_last_i), .img_ready_o(img_ready_o), .kick_i(kick_i),
        .kick_word_i(kick_word_i), .status_o(status_o), .err_code_o(err_code_o),
        .err_byte_o(err_byte_o)
    );

    int checks = 0;
    int errors = 0;
    int img_cnt = 0;
    int stall_n = 0;
    logic [23:0] exp_q[$];
    logic [7:0]  rep_q[$];

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // write-ready stall pattern, updated away from both edges
    initial begin
        wr_ready_i = 1'b0;
        forever begin
            @(posedge clk); #1;
            stall_n++;
            wr_ready_i = (stall_n % 4) != 3;
        end
    end

    // slave read model
    initial begin
        rd_valid_i = 1'b0;
        rd_data_i  = '0;
        forever begin
            @(negedge clk);
            if (rd_req_o && !rd_valid_i) begin
                if (rep_q.size() == 0) check("R4", "unexpected read", 32'd1, 32'd0);
                else rd_data_i = rep_q.pop_front();
                rd_valid_i = 1'b1;
            end else begin
                rd_valid_i = 1'b0;
            end
        end
    end

    // scoreboard monitor for the write channel
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && wr_valid_o && wr_ready_i) begin
                if (exp_q.size() == 0) check("R3", "unexpected write", {8'h0, wr_data_o}, 32'hFFFFFFFF);
                else check("R3", "write word", {8'h0, wr_data_o}, {8'h0, exp_q.pop_front()});
            end
            if (img_valid_i && img_ready_o) img_cnt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic launch();
        int lo = 0;
        int hi = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (!slv_rst_n_o && lo < 100) begin
            if (lo == 0) check("R1", "strap in reset", {29'h0, strap_o}, {29'h0, SWR, SRD, mode_par_i});
            lo++;
            @(negedge clk);
        end
        check("R1", "reset width", lo, RST);
        while (!wr_valid_o && hi < 100) begin
            if (hi == 0) check("R1", "strap in settle", {29'h0, strap_o}, {29'h0, SWR, SRD, mode_par_i});
            hi++;
            @(negedge clk);
        end
        check("R2", "settle gap", hi, SET);
        check("R1", "strap released", {29'h0, strap_o}, 32'h0);
        check("R10", "error cleared on start", {29'h0, err_code_o}, 32'h0);
    endtask

    task automatic wait_settled();
        int k = 0;
        while (status_o == 2'd1 && k < 3000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic feed(int n, logic [23:0] base);
        for (int i = 0; i < n; i++) begin
            bit took;
            img_valid_i = 1'b1;
            img_data_i  = base + 24'(i);
            img_last_i  = (i == n - 1);
            do begin
                took = img_ready_o;
                @(negedge clk);
            end while (!took);
        end
        img_valid_i = 1'b0;
        img_last_i  = 1'b0;
    endtask

    task automatic do_boot(string req, logic mp, logic [7:0] r1, int n, logic [7:0] r2,
                           logic [1:0] st, logic [2:0] code, logic [7:0] eb);
        logic [23:0] base = 24'h3A0000 + 24'(n);
        mode_par_i = mp;
        rdy_b      = 1'b1;
        img_cnt    = 0;
        exp_q.push_back(24'h000004);
        rep_q.push_back(r1);
        if (r1 == 8'h01) begin
            for (int i = 0; i < n; i++) exp_q.push_back(base + 24'(i));
            rep_q.push_back(r2);
            if (r2 == 8'h02) exp_q.push_back(24'h000005);
        end else begin
            img_valid_i = 1'b1;
            img_data_i  = 24'h00ABCD;
        end
        launch();
        if (r1 == 8'h01) feed(n, base);
        wait_settled();
        img_valid_i = 1'b0;
        check(req, "status", {30'h0, status_o}, {30'h0, st});
        check(req, "error code", {29'h0, err_code_o}, {29'h0, code});
        check(req, "error byte", {24'h0, err_byte_o}, {24'h0, eb});
        check(req, "writes outstanding", exp_q.size(), 0);
        check(req, "image words taken", img_cnt, (r1 == 8'h01) ? n : 0);
        check(req, "replies left", rep_q.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; kick_i = 1'b0; mode_par_i = 1'b0;
        timeout_i = 16'd40; kick_word_i = '0; rdy_b = 1'b1;
        img_valid_i = 1'b0; img_data_i = '0; img_last_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "idle status", {30'h0, status_o}, 32'd0);
        check("R11", "slave reset released", {31'h0, slv_rst_n_o}, 32'd1);
        check("R11", "no write", {31'h0, wr_valid_o}, 32'd0);
        check("R11", "no read", {31'h0, rd_req_o}, 32'd0);
        check("R11", "no error", {29'h0, err_code_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6 R8: serial success with five words
        do_boot("R6", 1'b0, 8'h01, 5, 8'h02, 2'd2, 3'd0, 8'h00);

        // R9: kickstart
        kick_word_i = 24'h5C1A7E;
        exp_q.push_back(24'h5C1A7E);
        @(negedge clk); kick_i = 1'b1;
        @(negedge clk); kick_i = 1'b0;
        wait_settled();
        check("R9", "status after kick", {30'h0, status_o}, 32'd2);
        check("R9", "kick written", exp_q.size(), 0);

        // R4 R6: parallel success, single last word
        do_boot("R4", 1'b1, 8'h01, 1, 8'h02, 2'd2, 3'd0, 8'h00);

        // R7: first reply failures
        do_boot("R7", 1'b0, 8'hFD, 0, 8'h00, 2'd3, 3'd1, 8'hFD);
        do_boot("R7", 1'b1, 8'hFE, 0, 8'h00, 2'd3, 3'd1, 8'hFE);
        do_boot("R7", 1'b0, 8'hFB, 0, 8'h00, 2'd3, 3'd2, 8'hFB);
        do_boot("R7", 1'b0, 8'hFA, 0, 8'h00, 2'd3, 3'd3, 8'hFA);
        do_boot("R7", 1'b1, 8'hFC, 0, 8'h00, 2'd3, 3'd3, 8'hFC);
        do_boot("R7", 1'b0, 8'h02, 0, 8'h00, 2'd3, 3'd3, 8'h02);

        // R8: second reply failures
        do_boot("R8", 1'b0, 8'h01, 3, 8'hFF, 2'd3, 3'd4, 8'hFF);
        do_boot("R8", 1'b1, 8'h01, 2, 8'hF0, 2'd3, 3'd5, 8'hF0);
        do_boot("R8", 1'b0, 8'h01, 2, 8'h37, 2'd3, 3'd3, 8'h37);

        // R5: timeout on the first wait
        mode_par_i = 1'b1; rdy_b = 1'b0; timeout_i = 16'd20;
        exp_q.push_back(24'h000004);
        launch();
        wait_settled();
        check("R5", "status", {30'h0, status_o}, 32'd3);
        check("R5", "code", {29'h0, err_code_o}, 32'd6);
        check("R5", "byte", {24'h0, err_byte_o}, 32'd0);
        check("R5", "writes outstanding", exp_q.size(), 0);

        // R4 R10: delayed ready in serial mode, start ignored while busy
        mode_par_i = 1'b0; rdy_b = 1'b0; timeout_i = 16'd200;
        exp_q.push_back(24'h000004);
        for (int i = 0; i < 4; i++) exp_q.push_back(24'h7E0000 + 24'(i));
        exp_q.push_back(24'h000005);
        rep_q.push_back(8'h01);
        rep_q.push_back(8'h02);
        launch();
        repeat (10) @(negedge clk);
        check("R4", "no read before ready", {31'h0, rd_req_o}, 32'd0);
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        check("R10", "start ignored: reset", {31'h0, slv_rst_n_o}, 32'd1);
        check("R10", "start ignored: busy", {30'h0, status_o}, 32'd1);
        rdy_b = 1'b1;
        feed(4, 24'h7E0000);
        wait_settled();
        check("R4", "done after delayed ready", {30'h0, status_o}, 32'd2);
        check("R10", "writes outstanding", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule